// File: doc/BRIEF.md
# Low Quadword Vector Move Unit

This unit executes and decode-checks a 64-bit partial move between memory and the low half of a vector register. In the load direction it places a 64-bit memory value into bits 63:0 of the destination register and builds the rest of the register according to the encoding class. In the store direction it sends bits 63:0 of a register to memory. The data is moved bit-exact: no floating-point interpretation, rounding or exception takes place.

The unit takes already decoded instruction fields: the encoding class (legacy, compact vector prefix or extended vector prefix), the opcode byte, the ModRM mod field, the 4-bit extra-source register selector, the vector-length bits and a flag telling whether a SIMD mandatory prefix (66, F2 or F3) was present. It also takes the current value of the ModRM.reg register, the register picked by the extra-source selector, and the memory read data. One cycle after an accepted input it presents a register write, a memory write, an invalid-opcode flag or a decode-reject flag. Address generation, the register file and other exception classes lie outside the unit.

Top module: `lqmove_unit`

## Requirements
- R1: Opcode byte 8'h12 selects a load (memory to register) and 8'h13 a store (register to memory). Any other opcode, a mod field of 2'b11, or encoding class 2'b11 asserts `rej_o` with `ud_o` low and no write.
- R2: A legacy-class (enc 2'b00) load writes memory bits 63:0 to destination bits 63:0 and returns bits MAXVL-1:64 of `reg_op_i` unchanged in `reg_wdata_o`.
- R3: A compact-prefix (enc 2'b01) or extended-prefix (enc 2'b10) load writes memory bits 63:0 to bits 63:0, copies bits 127:64 from `vsrc_i`, and clears bits MAXVL-1:128.
- R4: A store in any valid encoding class raises `mem_we_o` with `mem_wdata_o` equal to `reg_op_i[63:0]`, and keeps `reg_we_o` low.
- R5: A prefixed store (enc 2'b01 or 2'b10) with `vvvv_i` other than 4'b1111 raises `ud_o`. Loads accept any `vvvv_i`, and legacy stores ignore it.
- R6: With enc 2'b01, `len_i[0]` = 1 raises `ud_o`. With enc 2'b10, any `len_i` other than 2'b00 raises `ud_o`. The legacy class ignores `len_i`.
- R7: A legacy load with `simd_pfx_i` = 1 raises `ud_o`. A legacy store ignores `simd_pfx_i`.
- R8: While `ud_o` or `rej_o` is high, `reg_we_o` and `mem_we_o` are both low.
- R9: Data passes untouched. NaN, infinity and denormal bit patterns appear unchanged at the outputs.
- R10: Results appear exactly one cycle after `in_valid_i`, with `out_valid_o` high for that cycle only. Reset clears `out_valid_o` and every enable and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Decoded instruction present |
| enc_i | input | 2 | Encoding class: 0 legacy, 1 compact prefix, 2 extended prefix, 3 reserved |
| opc_i | input | 8 | Opcode byte |
| mod_i | input | 2 | ModRM mod field |
| vvvv_i | input | 4 | Extra-source register selector field |
| len_i | input | 2 | Vector-length bits |
| simd_pfx_i | input | 1 | A 66, F2 or F3 mandatory prefix is present |
| reg_op_i | input | MAXVL | Current value of the ModRM.reg register |
| vsrc_i | input | MAXVL | Register picked by the extra-source selector |
| mem_rdata_i | input | 64 | Memory read data |
| out_valid_o | output | 1 | Result valid |
| reg_we_o | output | 1 | Register write enable |
| reg_wdata_o | output | MAXVL | Register write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 64 | Memory write data |
| ud_o | output | 1 | Invalid-opcode flag |
| rej_o | output | 1 | Operand form not handled here |

## Verification
The hardest cases to reach are the invalid-opcode paths that depend on a single field combined with the encoding class. Examples are a prefixed store whose selector is anything but all ones, and an extended-class load whose length field is non-zero while the same value is legal for the legacy class. The directed tasks hold every other field at a legal value and flip only the field under test. They check that the flag rises, that both write enables stay low, and that the identical field value in a class that ignores it still produces a normal write.

// File: rtl/lqmove_pkg.sv
package lqmove_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY  = 2'd0,
    ENC_PFX_CMP = 2'd1,
    ENC_PFX_EXT = 2'd2,
    ENC_RSVD    = 2'd3
  } enc_e;

  localparam logic [7:0] OPC_LOAD  = 8'h12;
  localparam logic [7:0] OPC_STORE = 8'h13;
  localparam logic [3:0] SEL_NONE  = 4'hF;
  localparam logic [1:0] MOD_REG   = 2'b11;
  localparam int unsigned QW       = 64;

  typedef struct packed {
    logic ld;
    logic st;
    logic ud;
    logic rej;
  } dec_t;
endpackage

// File: rtl/lqmove_decode.sv
module lqmove_decode
  import lqmove_pkg::*;
(
  input  logic [1:0] enc_i,
  input  logic [7:0] opc_i,
  input  logic [1:0] mod_i,
  input  logic [3:0] vvvv_i,
  input  logic [1:0] len_i,
  input  logic       simd_pfx_i,
  output dec_t       dec_o
);
  enc_e enc;
  logic is_ld_op, is_st_op, form_ok, pfx_class;
  logic len_bad, sel_bad, mpfx_bad, ud;

  always_comb begin
    enc       = enc_e'(enc_i);
    is_ld_op  = (opc_i == OPC_LOAD);
    is_st_op  = (opc_i == OPC_STORE);
    pfx_class = (enc == ENC_PFX_CMP) || (enc == ENC_PFX_EXT);
    form_ok   = (pfx_class || enc == ENC_LEGACY) && (mod_i != MOD_REG) &&
                (is_ld_op || is_st_op);
    // length check: compact class uses one bit, extended class both
    len_bad   = ((enc == ENC_PFX_CMP) && len_i[0]) ||
                ((enc == ENC_PFX_EXT) && (len_i != 2'b00));
    sel_bad   = pfx_class && is_st_op && (vvvv_i != SEL_NONE);
    mpfx_bad  = (enc == ENC_LEGACY) && is_ld_op && simd_pfx_i;
    ud        = form_ok && (len_bad || sel_bad || mpfx_bad);
    dec_o.rej = !form_ok;
    dec_o.ud  = ud;
    dec_o.ld  = form_ok && !ud && is_ld_op;
    dec_o.st  = form_ok && !ud && is_st_op;
  end
endmodule

// File: rtl/lqmove_merge.sv
module lqmove_merge
  import lqmove_pkg::*;
#(
  parameter int unsigned MAXVL = 512
) (
  input  logic             legacy_i,
  input  logic [QW-1:0]    mem_i,
  input  logic [MAXVL-1:0] reg_op_i,
  input  logic [MAXVL-1:0] vsrc_i,
  output logic [MAXVL-1:0] wdata_o
);
  localparam int unsigned NLANE = MAXVL / QW;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign wdata_o[QW-1:0] = mem_i;
    end else if (l == 1) begin : g_mid
      assign wdata_o[2*QW-1:QW] = legacy_i ? reg_op_i[2*QW-1:QW] : vsrc_i[2*QW-1:QW];
    end else begin : g_up
      assign wdata_o[(l+1)*QW-1:l*QW] = legacy_i ? reg_op_i[(l+1)*QW-1:l*QW] : '0;
    end
  end
endmodule

// File: rtl/lqmove_outreg.sv
module lqmove_outreg
  import lqmove_pkg::*;
#(
  parameter int unsigned MAXVL = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  dec_t             dec_i,
  input  logic [MAXVL-1:0] rwdata_i,
  input  logic [QW-1:0]    mwdata_i,
  output logic             valid_o,
  output logic             reg_we_o,
  output logic             mem_we_o,
  output logic             ud_o,
  output logic             rej_o,
  output logic [MAXVL-1:0] rwdata_o,
  output logic [QW-1:0]    mwdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      reg_we_o <= 1'b0;
      mem_we_o <= 1'b0;
      ud_o     <= 1'b0;
      rej_o    <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      reg_we_o <= valid_i && dec_i.ld;
      mem_we_o <= valid_i && dec_i.st;
      ud_o     <= valid_i && dec_i.ud;
      rej_o    <= valid_i && dec_i.rej;
    end
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      rwdata_o <= rwdata_i;
      mwdata_o <= mwdata_i;
    end
  end
endmodule

// File: rtl/lqmove_unit.sv
module lqmove_unit
  import lqmove_pkg::*;
#(
  parameter int unsigned MAXVL = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [1:0]       enc_i,
  input  logic [7:0]       opc_i,
  input  logic [1:0]       mod_i,
  input  logic [3:0]       vvvv_i,
  input  logic [1:0]       len_i,
  input  logic             simd_pfx_i,
  input  logic [MAXVL-1:0] reg_op_i,
  input  logic [MAXVL-1:0] vsrc_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             out_valid_o,
  output logic             reg_we_o,
  output logic [MAXVL-1:0] reg_wdata_o,
  output logic             mem_we_o,
  output logic [63:0]      mem_wdata_o,
  output logic             ud_o,
  output logic             rej_o
);
  dec_t             dec;
  logic [MAXVL-1:0] merged;
  logic             legacy;

  assign legacy = (enc_i == ENC_LEGACY);

  lqmove_decode u_dec (
    .enc_i      (enc_i),
    .opc_i      (opc_i),
    .mod_i      (mod_i),
    .vvvv_i     (vvvv_i),
    .len_i      (len_i),
    .simd_pfx_i (simd_pfx_i),
    .dec_o      (dec)
  );

  lqmove_merge #(.MAXVL(MAXVL)) u_merge (
    .legacy_i (legacy),
    .mem_i    (mem_rdata_i),
    .reg_op_i (reg_op_i),
    .vsrc_i   (vsrc_i),
    .wdata_o  (merged)
  );

  lqmove_outreg #(.MAXVL(MAXVL)) u_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .dec_i    (dec),
    .rwdata_i (merged),
    .mwdata_i (reg_op_i[QW-1:0]),
    .valid_o  (out_valid_o),
    .reg_we_o (reg_we_o),
    .mem_we_o (mem_we_o),
    .ud_o     (ud_o),
    .rej_o    (rej_o),
    .rwdata_o (reg_wdata_o),
    .mwdata_o (mem_wdata_o)
  );

  AST_REJ_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (mod_i == MOD_REG) |=> rej_o && !ud_o); // R1
  AST_LEG_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && dec.ld && legacy |=>
      reg_wdata_o[MAXVL-1:QW] == $past(reg_op_i[MAXVL-1:QW])); // R2
  AST_PFX_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && dec.ld && !legacy |=>
      reg_wdata_o[2*QW-1:QW] == $past(vsrc_i[2*QW-1:QW])); // R3
  if (MAXVL > 2*QW) begin : g_zero_chk
    AST_PFX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && dec.ld && !legacy |=> reg_wdata_o[MAXVL-1:2*QW] == '0); // R3
  end
  AST_LOW_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && dec.ld |=> reg_we_o && reg_wdata_o[QW-1:0] == $past(mem_rdata_i)); // R9
  AST_STORE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && dec.st |=> mem_we_o && !reg_we_o &&
      mem_wdata_o == $past(reg_op_i[QW-1:0])); // R4
  AST_SEL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (enc_i == ENC_PFX_CMP || enc_i == ENC_PFX_EXT) &&
      opc_i == OPC_STORE && mod_i != MOD_REG && vvvv_i != SEL_NONE |=> ud_o); // R5
  AST_LEN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && enc_i == ENC_PFX_EXT && (opc_i == OPC_LOAD || opc_i == OPC_STORE) &&
      mod_i != MOD_REG && len_i != 2'b00 |=> ud_o); // R6
  AST_MPFX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && legacy && opc_i == OPC_LOAD && mod_i != MOD_REG && simd_pfx_i |=> ud_o); // R7
  AST_FAULT_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud_o || rej_o) |-> !reg_we_o && !mem_we_o); // R8
  AST_LAT_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R10
  AST_LAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && !reg_we_o && !mem_we_o && !ud_o && !rej_o); // R10
endmodule

// File: tb/tb_lqmove_unit.sv
`timescale 1ns/1ps
module tb_lqmove_unit;
  localparam int unsigned MAXVL = 512;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [1:0]       enc_i = '0;
  logic [7:0]       opc_i = '0;
  logic [1:0]       mod_i = '0;
  logic [3:0]       vvvv_i = '0;
  logic [1:0]       len_i = '0;
  logic             simd_pfx_i = 1'b0;
  logic [MAXVL-1:0] reg_op_i = '0;
  logic [MAXVL-1:0] vsrc_i = '0;
  logic [63:0]      mem_rdata_i = '0;
  logic             out_valid_o, reg_we_o, mem_we_o, ud_o, rej_o;
  logic [MAXVL-1:0] reg_wdata_o;
  logic [63:0]      mem_wdata_o;

  int n_chk = 0;
  int n_fail = 0;

  lqmove_unit #(.MAXVL(MAXVL)) dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [MAXVL-1:0] pat(input logic [31:0] seed);
    logic [MAXVL-1:0] v;
    for (int i = 0; i < MAXVL / 32; i++) v[i*32 +: 32] = seed ^ (32'h9E37_79B9 * (i + 1));
    return v;
  endfunction

  task automatic chk(input string r, input logic [MAXVL-1:0] act, input logic [MAXVL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // drive one op, wait one cycle, compare all outputs
  task automatic run(input string r, input logic [1:0] enc, input logic [7:0] opc,
                     input logic [1:0] md, input logic [3:0] sel, input logic [1:0] len,
                     input logic pfx, input logic [63:0] mem,
                     input logic e_rwe, input logic e_mwe, input logic e_ud, input logic e_rej,
                     input logic [MAXVL-1:0] e_rdata, input logic [63:0] e_mdata);
    @(negedge clk_i);
    in_valid_i = 1'b1; enc_i = enc; opc_i = opc; mod_i = md; vvvv_i = sel;
    len_i = len; simd_pfx_i = pfx; mem_rdata_i = mem;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk({r, " flags"}, MAXVL'({out_valid_o, reg_we_o, mem_we_o, ud_o, rej_o}),
        MAXVL'({1'b1, e_rwe, e_mwe, e_ud, e_rej}));
    if (e_rwe) chk({r, " rdata"}, reg_wdata_o, e_rdata);
    if (e_mwe) chk({r, " mdata"}, MAXVL'(mem_wdata_o), MAXVL'(e_mdata));
  endtask

  function automatic logic [MAXVL-1:0] leg_ld(input logic [63:0] m);
    return {reg_op_i[MAXVL-1:64], m};
  endfunction
  function automatic logic [MAXVL-1:0] pfx_ld(input logic [63:0] m);
    logic [MAXVL-1:0] v = '0;
    v[127:64] = vsrc_i[127:64];
    v[63:0] = m;
    return v;
  endfunction

  task automatic t_reset;
    chk("R10 reset", MAXVL'({out_valid_o, reg_we_o, mem_we_o, ud_o, rej_o}), '0);
  endtask

  task automatic t_legacy_load;
    run("R2 leg ld", 2'd0, 8'h12, 2'b00, 4'h0, 2'b00, 1'b0, 64'h0123_4567_89AB_CDEF,
        1, 0, 0, 0, leg_ld(64'h0123_4567_89AB_CDEF), '0);
    run("R6 leg len ignored", 2'd0, 8'h12, 2'b10, 4'h5, 2'b11, 1'b0, 64'hDEAD_BEEF_0000_0001,
        1, 0, 0, 0, leg_ld(64'hDEAD_BEEF_0000_0001), '0);
  endtask

  task automatic t_pfx_load;
    run("R3 cmp ld", 2'd1, 8'h12, 2'b01, 4'h3, 2'b00, 1'b0, 64'hCAFE_F00D_1234_5678,
        1, 0, 0, 0, pfx_ld(64'hCAFE_F00D_1234_5678), '0);
    run("R3 ext ld", 2'd2, 8'h12, 2'b00, 4'h0, 2'b00, 1'b1, 64'h5555_AAAA_3333_CCCC,
        1, 0, 0, 0, pfx_ld(64'h5555_AAAA_3333_CCCC), '0);
  endtask

  task automatic t_store;
    run("R4 leg st", 2'd0, 8'h13, 2'b00, 4'h2, 2'b11, 1'b1, '0, 0, 1, 0, 0, '0, reg_op_i[63:0]);
    run("R4 cmp st", 2'd1, 8'h13, 2'b01, 4'hF, 2'b00, 1'b0, '0, 0, 1, 0, 0, '0, reg_op_i[63:0]);
    run("R4 ext st", 2'd2, 8'h13, 2'b10, 4'hF, 2'b00, 1'b0, '0, 0, 1, 0, 0, '0, reg_op_i[63:0]);
  endtask

  task automatic t_sel_rsvd;
    run("R5 cmp st sel", 2'd1, 8'h13, 2'b00, 4'hE, 2'b00, 1'b0, '0, 0, 0, 1, 0, '0, '0);
    run("R5 ext st sel", 2'd2, 8'h13, 2'b00, 4'h7, 2'b00, 1'b0, '0, 0, 0, 1, 0, '0, '0);
  endtask

  task automatic t_len;
    run("R6 cmp L", 2'd1, 8'h12, 2'b00, 4'h1, 2'b01, 1'b0, 64'h1, 0, 0, 1, 0, '0, '0);
    run("R6 cmp hi bit", 2'd1, 8'h12, 2'b00, 4'h1, 2'b10, 1'b0, 64'h2,
        1, 0, 0, 0, pfx_ld(64'h2), '0);
    run("R6 ext 01", 2'd2, 8'h13, 2'b00, 4'hF, 2'b01, 1'b0, '0, 0, 0, 1, 0, '0, '0);
    run("R6 ext 10", 2'd2, 8'h12, 2'b00, 4'h0, 2'b10, 1'b0, 64'h3, 0, 0, 1, 0, '0, '0);
  endtask

  task automatic t_mpfx;
    run("R7 leg ld pfx", 2'd0, 8'h12, 2'b00, 4'h0, 2'b00, 1'b1, 64'h4, 0, 0, 1, 0, '0, '0);
  endtask

  task automatic t_reject;
    run("R1 mod reg", 2'd0, 8'h12, 2'b11, 4'h0, 2'b00, 1'b0, 64'h5, 0, 0, 0, 1, '0, '0);
    run("R1 bad opc", 2'd1, 8'h14, 2'b00, 4'hF, 2'b00, 1'b0, 64'h6, 0, 0, 0, 1, '0, '0);
    run("R1 rsvd enc", 2'd3, 8'h13, 2'b00, 4'hF, 2'b00, 1'b0, 64'h7, 0, 0, 0, 1, '0, '0);
    run("R8 mod reg bad len", 2'd2, 8'h13, 2'b11, 4'h0, 2'b11, 1'b0, '0, 0, 0, 0, 1, '0, '0);
  endtask

  task automatic t_raw_data;
    run("R9 nan ld", 2'd0, 8'h12, 2'b00, 4'h0, 2'b00, 1'b0, 64'h7FC0_0001_FF80_0000,
        1, 0, 0, 0, leg_ld(64'h7FC0_0001_FF80_0000), '0);
    run("R9 denorm ld", 2'd2, 8'h12, 2'b01, 4'h9, 2'b00, 1'b0, 64'h0000_0001_807F_FFFF,
        1, 0, 0, 0, pfx_ld(64'h0000_0001_807F_FFFF), '0);
    reg_op_i[63:0] = 64'hFFFF_FFFF_7F80_0001;
    run("R9 nan st", 2'd0, 8'h13, 2'b00, 4'h0, 2'b00, 1'b0, '0, 0, 1, 0, 0, '0,
        64'hFFFF_FFFF_7F80_0001);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    in_valid_i = 1'b1; enc_i = 2'd0; opc_i = 8'h12; mod_i = 2'b00; simd_pfx_i = 1'b0;
    mem_rdata_i = 64'hAAAA_0000_0000_0001;
    @(negedge clk_i);
    chk("R10 b2b first", reg_wdata_o, leg_ld(64'hAAAA_0000_0000_0001));
    opc_i = 8'h13;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R10 b2b second", MAXVL'({out_valid_o, reg_we_o, mem_we_o}), MAXVL'(3'b101));
    @(negedge clk_i);
    chk("R10 idle", MAXVL'({out_valid_o, reg_we_o, mem_we_o, ud_o, rej_o}), '0);
  endtask

  initial begin
    reg_op_i = pat(32'h1111_2222);
    vsrc_i = pat(32'h3333_4444);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_legacy_load();
    t_pfx_load();
    t_store();
    t_sel_rsvd();
    t_len();
    t_mpfx();
    t_reject();
    t_raw_data();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule